// File: doc/BRIEF.md
# Selectable Multi-Channel Input Debouncer

This block cleans up eight slow field inputs before they are captured into a parallel-load shift register. Each raw input first goes through a two-stage synchronizer. It then passes through its own qualification filter. A filtered output takes a new level only after the synchronized input has held that level for the whole selected time. The rule is the same for rising and falling changes.

A 2-bit strap input selects the qualification time. The choices are a long time, a short time, or no filtering. The fourth code is reserved and behaves like the long setting. One shared timebase divides the system clock down to millisecond ticks. Each channel counts those ticks while its input disagrees with its output. The number of clock cycles per millisecond is a parameter, so a simulation can use a small value.

Top module: `sel_debounce`

## Requirements
- R1: While rst_ni is low, and right after it is released, every bit of filt_o is 0.
- R2: With sel_i = 2'b11, the qualification time is LONG_MS ticks (default 3). Take P = CYC_PER_MS clock cycles per tick and N = LONG_MS. After the raw input changes, filt_o keeps its old value for at least (N-1)*P+2 rising clock edges. It shows the new value after at most N*P+2 rising edges.
- R3: With sel_i = 2'b10, the qualification time is SHORT_MS ticks (default 1). The edge window is the same as in R2, with N = SHORT_MS.
- R4: With sel_i = 2'b01, the filter is bypassed. filt_o equals raw_i delayed by exactly three rising clock edges.
- R5: The reserved code sel_i = 2'b00 gives the same timing as sel_i = 2'b11.
- R6: Rising and falling changes follow the same qualification rule.
- R7: Each of the NUM_CH channels is filtered independently. Activity on one channel never changes the output or the timing of another channel.
- R8: If the synchronized input returns to the current output level before qualification completes, that channel's count restarts. A later change needs the full time again.
- R9: While the input of a channel stays equal to its output, that output never changes. Any change of filt_o is always toward the synchronized input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Filter time select: 11 long, 10 short, 01 bypass, 00 reserved (long) |
| raw_i | input | NUM_CH | Asynchronous field inputs |
| filt_o | output | NUM_CH | Debounced levels, one per channel |

## Verification
The bench places its samples just inside each edge of the qualification window. A filter that is one tick short changes too early. A filter that is one tick long never reaches the new level in time.

A pulse that falls one tick short of qualifying is followed by a brief return and then a fresh change. A design that fails to clear its count would accept the second change at the first tick.

The reserved code and the falling direction are timed on the same window. Either of these would expose a design that bypasses or ignores that case.

Glitches on a neighbouring channel during a qualification would reveal counters or enables that are shared by mistake.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic [1:0] {
    SEL_RSVD  = 2'b00,
    SEL_BYP   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_LONG  = 2'b11
  } dbnc_sel_e;
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
  parameter int unsigned CYC_PER_MS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic             tick_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (bypass_i) begin
      cnt_q <= '0;
      out_o <= in_i;
    end else if (in_i == out_o) begin
      cnt_q <= '0;  // agreement (or glitch back) restarts qualification
    end else if (tick_i) begin
      if (cnt_nxt >= {1'b0, lim_i}) begin
        cnt_q <= '0;
        out_o <= in_i;
      end else begin
        cnt_q <= cnt_nxt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/sel_debounce.sv
module sel_debounce #(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned CYC_PER_MS = 50000,
  parameter int unsigned LONG_MS    = 3,
  parameter int unsigned SHORT_MS   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic [NUM_CH-1:0] raw_i,
  output logic [NUM_CH-1:0] filt_o
);
  import dbnc_pkg::*;

  localparam int unsigned CNT_W = $clog2(LONG_MS + 1);

  logic [NUM_CH-1:0] raw_s;
  logic              ms_tick;
  logic              bypass;
  logic [CNT_W-1:0]  lim;

  always_comb begin
    bypass = 1'b0;
    lim    = CNT_W'(LONG_MS);
    unique case (dbnc_sel_e'(sel_i))
      SEL_BYP:   bypass = 1'b1;
      SEL_SHORT: lim    = CNT_W'(SHORT_MS);
      default:   lim    = CNT_W'(LONG_MS);  // long and reserved
    endcase
  end

  dbnc_sync #(.WIDTH(NUM_CH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (raw_s)
  );

  dbnc_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (ms_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dbnc_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .in_i     (raw_s[g]),
      .tick_i   (ms_tick),
      .bypass_i (bypass),
      .lim_i    (lim),
      .out_o    (filt_o[g])
    );
  end
endmodule

// File: rtl/sel_debounce_chk.sv
module sel_debounce_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        sel_i,
  input logic [NUM_CH-1:0] sync_q,
  input logic              tick,
  input logic [NUM_CH-1:0] filt_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (filt_o == '0);
    end
  end

  a_r4_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b01) |=> (filt_o == $past(sync_q)));

  a_r9_hold_when_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 2'b01 && sync_q == filt_o) |=> $stable(filt_o));

  a_r2_change_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 2'b01 && !tick) |=> $stable(filt_o));

  a_r9_toward_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((filt_o ^ $past(filt_o)) & ~($past(sync_q) ^ $past(filt_o))) == '0));
endmodule

bind sel_debounce sel_debounce_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .sync_q (raw_s),
  .tick   (ms_tick),
  .filt_o (filt_o)
);

// File: tb/sel_debounce_tb.sv
module sel_debounce_tb;
  localparam int P    = 10;
  localparam int NL   = 3;
  localparam int NS   = 1;
  localparam int NCH  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     sel = 2'b11;
  logic [NCH-1:0] raw = '0;
  logic [NCH-1:0] filt;
  int             n_chk = 0;
  int             n_err = 0;
  bit             done = 1'b0;

  always #10 clk = ~clk;

  sel_debounce #(.NUM_CH(NCH), .CYC_PER_MS(P), .LONG_MS(NL), .SHORT_MS(NS)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .raw_i  (raw),
    .filt_o (filt)
  );

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  // force a known state through the bypass path, then choose the mode
  task automatic settle(input logic [NCH-1:0] v, input logic [1:0] s);
    sel = 2'b01;
    raw = v;
    wait_edges(5);
    sel = s;
    wait_edges(2);
  endtask

  // drive new value, check the window for N ticks
  task automatic window(input string req, input int n, input logic [NCH-1:0] v_old,
                        input logic [NCH-1:0] v_new);
    raw = v_new;
    wait_edges((n - 1) * P + 2);
    check(req, filt, v_old);
    wait_edges(P);
    check(req, filt, v_new);
  endtask

  task automatic t_reset;
    raw = '1;
    wait_edges(4);
    check("R1 in reset", filt, '0);
    raw = '0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);
    check("R1 after release", filt, '0);
  endtask

  task automatic t_long;
    settle('0, 2'b11);
    window("R2 long rise", NL, 8'h00, 8'h01);
    window("R6 long fall", NL, 8'h01, 8'h00);
  endtask

  task automatic t_short;
    settle(8'h00, 2'b10);
    window("R3 short rise", NS, 8'h00, 8'h80);
    window("R6 short fall", NS, 8'h80, 8'h00);
  endtask

  task automatic t_bypass;
    settle(8'h00, 2'b01);
    raw = 8'h08;
    wait_edges(2);
    check("R4 bypass before", filt, 8'h00);
    wait_edges(1);
    check("R4 bypass rise", filt, 8'h08);
    raw = 8'h00;
    wait_edges(2);
    check("R4 bypass hold", filt, 8'h08);
    wait_edges(1);
    check("R4 bypass fall", filt, 8'h00);
  endtask

  task automatic t_reserved;
    settle(8'h00, 2'b00);
    window("R5 reserved rise", NL, 8'h00, 8'h04);
    window("R5 reserved fall", NL, 8'h04, 8'h00);
  endtask

  task automatic t_glitch;
    settle(8'h00, 2'b11);
    raw = 8'h02;
    repeat ((NL - 1) * P) @(posedge clk);
    @(negedge clk);
    raw = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 no accept on short pulse", filt, 8'h00);
    window("R8 restart after glitch", NL, 8'h00, 8'h02);
  endtask

  task automatic t_indep;
    settle(8'h00, 2'b11);
    raw = 8'h10;
    for (int i = 0; i < (NL - 1) * P + 2; i++) begin
      @(posedge clk);
      @(negedge clk);
      raw[6] = ~raw[6];
      if (i % 3 == 0) raw[2] = ~raw[2];
    end
    raw[6] = 1'b0;
    raw[2] = 1'b0;
    check("R7 ch4 not yet", filt, 8'h00);
    wait_edges(P - 1);
    check("R7 ch4 on time, others quiet", filt, 8'h10);
  endtask

  task automatic t_hold;
    settle(8'h5a, 2'b11);
    wait_edges(NL * P * 3);
    check("R9 stable long mode", filt, 8'h5a);
    sel = 2'b10;
    wait_edges(NS * P * 3);
    check("R9 stable short mode", filt, 8'h5a);
  endtask

  initial begin
    t_reset();
    t_long();
    t_short();
    t_bypass();
    t_reserved();
    t_glitch();
    t_indep();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule